// File: doc/BRIEF.md
# Distributed-Arithmetic FIR Filter with Halved Group Tables

The block is a fixed-coefficient FIR filter that has no multipliers. Each accepted two's-complement sample enters an N-tap delay line. The inner product of the delay line with the coefficient set is then formed by distributed arithmetic. Every cycle the datapath takes one digit of several bits from every stored sample, starting with the most significant digit. It looks up precomputed coefficient combinations and folds them into a shift-accumulator. Once the last digit has been processed, the block presents the exact full-precision result together with a one-cycle done strobe.

The taps are split into groups of K. Each group has its own small table, so total storage grows linearly with the tap count. Each table is stored in offset-binary form, which makes the full table antisymmetric. Only the half in which the group's top address bit is one is kept. When that bit is zero, XOR gates invert the lower address bits and a multiplexer selects the negated word. An adder tree sums the groups and the bit weights within the digit. The constant offset term is removed once per output. The coefficients are parameters, and the tables are filled when the design is elaborated.

Top module: `da_fir_halflut`

## Requirements
- R1: While reset is asserted and on the first cycle after it, in_ready is 1, out_done is 0 and out_result is 0.
- R2: Each out_result equals the exact signed sum over k of COEF[k] times the sample accepted k acceptances earlier, with k = 0 for the newest sample. Samples and coefficients are two's complement. Delay-line positions not yet filled since reset count as zero.
- R3: A sample is accepted on a rising edge where in_valid and in_ready are both 1. out_done is 1 for exactly one cycle, the cycle after the SAMP_W/DIGIT_W-th rising edge that follows the acceptance edge. With the defaults that is 4 edges.
- R4: in_ready is 0 from the acceptance edge until the cycle in which out_done is 1. While in_ready is 0, in_valid and in_sample are ignored and leave the delay line unchanged.
- R5: out_result keeps its value in every cycle in which out_done is 0.
- R6: Samples at the range ends (-2^(SAMP_W-1) and 2^(SAMP_W-1)-1), combined with coefficients at their own range ends, give exact results with no wrap.
- R7: Idle cycles (in_valid low while in_ready is 1) do not shift the delay line, whatever value in_sample carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A sample is offered on in_sample |
| in_sample | input | SAMP_W | Two's-complement input sample |
| in_ready | output | 1 | The block can accept a sample this cycle |
| out_done | output | 1 | One-cycle strobe: out_result has just been updated |
| out_result | output | OUT_W | Signed filter output, full precision |

## Verification
The embedded properties watch the handshake on every cycle. They check that done is a single-cycle pulse that only follows a run of digit cycles, that ready falls after an acceptance, that the delay line stays frozen while digits are processed, and that the result holds between strobes. Only the bench's scenarios can show whether the numbers are right. It compares every done strobe against a behavioural dot product across an impulse, random samples, range-end samples, a continuously held valid with changing data, and long idle gaps. The same comparison shows that the exact strobe cycle matches the digit count.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // Offset-binary weight of one coefficient: bit 1 -> +h, bit 0 -> -h
    function automatic int obc_term(input logic b, input int h);
        return b ? h : -h;
    endfunction

    // Width of one group table word holding a signed sum of k coefficients
    function automatic int group_word_w(input int cw, input int k);
        return cw + $clog2(k) + 1;
    endfunction

endpackage

// File: rtl/da_fir_half_lut.sv
module da_fir_half_lut #(
    parameter int NT    = 8,
    parameter int K     = 4,
    parameter int CW    = 8,
    parameter int LW    = 11,
    parameter int GBASE = 0,
    parameter int COEF [NT] = '{default: 0}
) (
    input  logic [K-1:0]          bits,
    output logic signed [LW-1:0]  val
);
    import da_fir_pkg::*;

    localparam int HALF = 2 ** (K - 1);

    // Entry for address a with the group's top bit taken as 1
    function automatic int entry(input int a);
        int s;
        s = COEF[GBASE + K - 1];
        for (int i = 0; i < K - 1; i++) begin
            s = s + obc_term(((a >> i) & 1) == 1, COEF[GBASE + i]);
        end
        return s;
    endfunction

    logic signed [LW-1:0] rom [HALF];

    for (genvar a = 0; a < HALF; a++) begin : g_rom
        assign rom[a] = LW'(entry(a));
    end

    logic [K-2:0]         addr;
    logic signed [LW-1:0] word;

    always_comb begin
        addr = bits[K-1] ? bits[K-2:0] : ~bits[K-2:0];
        word = rom[addr];
        val  = bits[K-1] ? word : -word;
    end

endmodule

// File: rtl/da_fir_digit_sum.sv
module da_fir_digit_sum #(
    parameter int NT = 8,
    parameter int K  = 4,
    parameter int CW = 8,
    parameter int D  = 2,
    parameter int LW = 11,
    parameter int PW = 15,
    parameter int COEF [NT] = '{default: 0}
) (
    input  logic [D-1:0][NT-1:0] slice,
    input  logic                 sign_dig,
    output logic signed [PW-1:0] part
);
    localparam int G = NT / K;

    logic signed [LW-1:0] lv [D][G];

    for (genvar i = 0; i < D; i++) begin : g_bit
        for (genvar g = 0; g < G; g++) begin : g_grp
            da_fir_half_lut #(
                .NT(NT), .K(K), .CW(CW), .LW(LW), .GBASE(g * K), .COEF(COEF)
            ) u_lut (
                .bits (slice[i][g*K +: K]),
                .val  (lv[i][g])
            );
        end
    end

    always_comb begin
        logic signed [PW-1:0] bsum;
        logic signed [PW-1:0] weighted;
        part = '0;
        for (int i = 0; i < D; i++) begin
            bsum = '0;
            for (int g = 0; g < G; g++) begin
                bsum = bsum + $signed({{(PW-LW){lv[i][g][LW-1]}}, lv[i][g]});
            end
            weighted = bsum <<< i;
            if (sign_dig && (i == D - 1)) part = part - weighted;
            else                          part = part + weighted;
        end
    end

endmodule

// File: rtl/da_fir_halflut.sv
module da_fir_halflut #(
    parameter int N_TAPS  = 8,
    parameter int SAMP_W  = 8,
    parameter int COEF_W  = 8,
    parameter int DIGIT_W = 2,
    parameter int GROUP_K = 4,
    parameter int COEF [N_TAPS] = '{-128, 127, 5, -3, 60, -90, 1, 17},
    parameter int OUT_W   = COEF_W + SAMP_W + $clog2(N_TAPS) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [SAMP_W-1:0] in_sample,
    output logic              in_ready,
    output logic              out_done,
    output logic [OUT_W-1:0]  out_result
);
    import da_fir_pkg::*;

    localparam int NDIG = SAMP_W / DIGIT_W;
    localparam int DGW  = (NDIG > 1) ? $clog2(NDIG) : 1;
    localparam int BIW  = (SAMP_W > 1) ? $clog2(SAMP_W) : 1;
    localparam int G    = N_TAPS / GROUP_K;
    localparam int LW   = group_word_w(COEF_W, GROUP_K);
    localparam int PW   = LW + $clog2(G) + DIGIT_W + 1;
    localparam int AW   = OUT_W + 1;

    function automatic int coef_sum();
        int s;
        s = 0;
        for (int k = 0; k < N_TAPS; k++) s = s + COEF[k];
        return s;
    endfunction

    localparam int HSUM = coef_sum();

    run_state_e           st;
    logic [DGW-1:0]       dig;
    logic [SAMP_W-1:0]    taps [N_TAPS];
    logic signed [AW-1:0] acc;
    logic signed [AW-1:0] acc_next;
    logic signed [AW-1:0] part_x;
    logic signed [AW-1:0] res_full;
    logic signed [PW-1:0] part;
    logic [DIGIT_W-1:0][N_TAPS-1:0] slice;
    logic                 sign_dig;

    // Gather the current digit of every stored sample
    always_comb begin
        logic [BIW-1:0] bpos;
        for (int i = 0; i < DIGIT_W; i++) begin
            bpos = BIW'(int'(dig) * DIGIT_W + i);
            for (int k = 0; k < N_TAPS; k++) begin
                slice[i][k] = taps[k][bpos];
            end
        end
        sign_dig = (dig == DGW'(NDIG - 1));
    end

    da_fir_digit_sum #(
        .NT(N_TAPS), .K(GROUP_K), .CW(COEF_W), .D(DIGIT_W),
        .LW(LW), .PW(PW), .COEF(COEF)
    ) u_digit (
        .slice    (slice),
        .sign_dig (sign_dig),
        .part     (part)
    );

    always_comb begin
        part_x   = $signed({{(AW-PW){part[PW-1]}}, part});
        acc_next = (acc <<< DIGIT_W) + part_x;
        res_full = acc_next - AW'(HSUM);
    end

    assign in_ready = (st == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            dig        <= '0;
            acc        <= '0;
            out_done   <= 1'b0;
            out_result <= '0;
            for (int k = 0; k < N_TAPS; k++) taps[k] <= '0;
        end else begin
            out_done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (in_valid) begin
                        for (int k = N_TAPS - 1; k > 0; k--) taps[k] <= taps[k-1];
                        taps[0] <= in_sample;
                        dig     <= DGW'(NDIG - 1);
                        acc     <= '0;
                        st      <= ST_RUN;
                    end
                end
                default: begin
                    if (dig == '0) begin
                        out_result <= res_full[OUT_W:1];
                        out_done   <= 1'b1;
                        acc        <= '0;
                        st         <= ST_IDLE;
                    end else begin
                        acc <= acc_next;
                        dig <= dig - 1'b1;
                    end
                end
            endcase
        end
    end

    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (rst)
        out_done |-> $past(st == ST_RUN)); // R3
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        out_done |=> !out_done); // R3
    AST_DIG_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN) |-> (int'(dig) < NDIG)); // R3
    AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
        (in_ready && in_valid) |=> !in_ready); // R4
    AST_TAPS_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RUN) |=> ($stable(taps[0]) && $stable(taps[N_TAPS-1]))); // R4
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !out_done |-> $stable(out_result)); // R5

endmodule

// File: tb/da_fir_halflut_bench.sv
module da_fir_halflut_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NT   = 8;
    localparam int SW   = 8;
    localparam int CW   = 8;
    localparam int DW   = 2;
    localparam int NDIG = SW / DW;
    localparam int OW   = CW + SW + $clog2(NT) + 1;
    localparam int BCOEF [NT] = '{-128, 127, 5, -3, 60, -90, 1, 17};

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [SW-1:0] in_sample;
    logic          in_ready;
    logic          out_done;
    logic [OW-1:0] out_result;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    bit chk_on = 1'b0;
    string cur_req = "R2";

    // behavioural model state
    int hist [NT];
    int cnt = 0;
    bit exp_done = 1'b0;
    int exp_res = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    da_fir_halflut #(
        .N_TAPS(NT), .SAMP_W(SW), .COEF_W(CW), .DIGIT_W(DW), .GROUP_K(4),
        .COEF(BCOEF)
    ) u_da_fir_halflut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .in_ready(in_ready), .out_done(out_done), .out_result(out_result)
    );

    function automatic int dot();
        int s;
        s = 0;
        for (int k = 0; k < NT; k++) s = s + BCOEF[k] * hist[k];
        return s;
    endfunction

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // reference model, advanced at each rising edge
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            cnt = 0;
            exp_done = 1'b0;
            exp_res = 0;
            for (int k = 0; k < NT; k++) hist[k] = 0;
        end else begin
            exp_done = 1'b0;
            if (cnt == 0) begin
                if (in_valid) begin
                    for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
                    hist[0] = int'($signed(in_sample));
                    cnt = NDIG;
                end
            end else begin
                if (cnt == 1) begin
                    exp_done = 1'b1;
                    exp_res = dot();
                end
                cnt = cnt - 1;
            end
        end
        if (cyc > 100000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual cyc=%0d expected <=100000", cyc);
            report();
            $finish;
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (chk_on) begin
            checks++;
            if (in_ready !== (cnt == 0)) begin
                errors++;
                $display("FAIL R4: in_ready actual=%0b expected=%0b", in_ready, (cnt == 0));
            end
            checks++;
            if (out_done !== exp_done) begin
                errors++;
                $display("FAIL R3: out_done actual=%0b expected=%0b", out_done, exp_done);
            end
            checks++;
            if (int'($signed(out_result)) != exp_res) begin
                errors++;
                if (exp_done)
                    $display("FAIL %s: out_result actual=%0d expected=%0d",
                             cur_req, $signed(out_result), exp_res);
                else
                    $display("FAIL R5: held out_result actual=%0d expected=%0d",
                             $signed(out_result), exp_res);
            end
        end
    end

    task automatic send(input int v);
        @(negedge clk);
        in_valid = 1'b1;
        in_sample = SW'(v);
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        rst = 1'b1;
        in_valid = 1'b0;
        in_sample = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        checks++;
        if (in_ready !== 1'b1 || out_done !== 1'b0 || out_result !== '0) begin
            errors++;
            $display("FAIL R1: ready/done/result actual=%0b/%0b/%0d expected=1/0/0",
                     in_ready, out_done, $signed(out_result));
        end
        chk_on = 1'b1;

        // R2: impulse walks through every tap
        cur_req = "R2";
        send(1);
        for (int i = 0; i < NT; i++) send(0);

        // R2: random samples
        for (int i = 0; i < 30; i++) send(int'($urandom_range(255)) - 128);

        // R6: range-end samples
        cur_req = "R6";
        for (int i = 0; i < NT; i++) send(-128);
        for (int i = 0; i < NT; i++) send(127);
        for (int i = 0; i < 2 * NT; i++) send((i % 2 == 0) ? -128 : 127);

        // R4: valid held high, data changes every cycle, also while busy
        cur_req = "R4";
        @(negedge clk);
        in_valid = 1'b1;
        for (int i = 0; i < 60; i++) begin
            in_sample = SW'($urandom_range(255));
            @(negedge clk);
        end
        in_valid = 1'b0;

        // R7: idle gaps with changing data on in_sample
        cur_req = "R7";
        for (int i = 0; i < 10; i++) begin
            send(int'($urandom_range(255)) - 128);
            for (int j = 0; j < 7; j++) begin
                in_sample = SW'($urandom_range(255));
                @(negedge clk);
            end
        end

        repeat (NDIG + 4) @(negedge clk);
        chk_on = 1'b0;
        report();
        $finish;
    end

endmodule